// File: doc/BRIEF.md
# Parameterized ALU with Status Flags

A purely combinational arithmetic-logic unit. Two `W`-bit operands and a 5-bit function code select one of nine operations: add, subtract, three shifts and four bitwise logic operations. The unit returns a `W`-bit result together with negative, carry, overflow and zero flags. There are no registers inside, so the outputs follow the inputs within the same cycle. The surrounding datapath supplies the clocking.

The function code is decoded by bit fields, and some of its bits are don't-cares. Bits [1:0] pick the family: `01` is arithmetic, `10` is shift and `00` is logic. Bit 4 picks subtract over add and is ignored by every other family. Bits [3:2] pick the member within the shift and logic families. A shift moves operand `b_i` by an amount taken from the low bits of operand `a_i`. A code outside the listed patterns yields a zero result.

Top module: `alu_flags`

## Requirements
- R1: Codes matching `0??01` give `r_o = (a_i + b_i) mod 2^W`, and `carry_o` is the carry out of the top bit (10+20 gives 30).
- R2: Codes matching `1??01` give `r_o = (a_i - b_i) mod 2^W`, and `carry_o` is 1 exactly when `a_i >= b_i` as unsigned values, meaning no borrow (10-20 gives 0xF6 with carry 0; 1-1 gives 0 with carry 1).
- R3: For add and subtract, `ovf_o` is 1 exactly when the two's-complement result falls outside the signed W-bit range (100+30 sets it; 0x80-0x01 sets it).
- R4: Codes matching `?0010` give `r_o = b_i` shifted left by the amount, with zeros entering (amount 2, b 20 gives 80).
- R5: Codes matching `?1010` give `r_o = b_i` shifted right by the amount, with zeros entering (amount 2, b 20 gives 5).
- R6: Codes matching `?1110` give `r_o = b_i` shifted right by the amount, with copies of `b_i[W-1]` entering (amount 1, b 0xFE gives 0xFF).
- R7: Codes `?0000`, `?0100`, `?1000` and `?1100` give the bitwise AND, OR, XOR and NOR of `a_i` and `b_i`.
- R8: Bit 4 of the function code has no effect on the shift and logic families.
- R9: For every shift and logic code, `carry_o` and `ovf_o` are 0.
- R10: The shift amount is `a_i[log2(W)-1:0]`, and higher bits of `a_i` are ignored (with W=8, `a_i`=0x0A shifts by 2 and `a_i`=0x08 shifts by 0).
- R11: A code with bits [1:0] = `11`, or the shift code `?0110`, gives `r_o = 0`, `carry_o = 0` and `ovf_o = 0`.
- R12: `neg_o` equals `r_o[W-1]`, and `zero_o` is 1 exactly when every bit of `r_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand; shift amount source for shifts |
| b_i | input | W | Second operand; shifted value for shifts |
| fn_i | input | 5 | Function code |
| r_o | output | W | Result |
| neg_o | output | 1 | Result sign bit |
| carry_o | output | 1 | Carry out, or no-borrow on subtract |
| ovf_o | output | 1 | Signed overflow on add/subtract |
| zero_o | output | 1 | Result is all zeros |

## Verification
Arithmetic is tried with small positive sums and differences, a sum that crosses into the sign bit, an unsigned wrap, a negative-minus-positive overflow and an exact cancellation. Together these separate carry from overflow and borrow from no-borrow. The shifts use a value whose sign bit is set, so the logical and arithmetic right shifts can be told apart, and amounts with high bits set show that only the low amount bits are used. The logic operations use complementary nibble patterns, so that each of AND, OR, XOR and NOR yields a distinct byte. Each shift and logic code is repeated with bit 4 set, the unlisted codes are applied, and a grid sweep compares every output against a model computed in the bench.

// File: rtl/alu_flags.sv
`timescale 1ns / 1ps
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   fn_i,
  output logic [W-1:0] r_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         zero_o
);
  localparam int SW = (W > 1) ? $clog2(W) : 1;

  logic          sub;
  logic [W-1:0]  b_eff;
  logic [W:0]    sum;
  logic [SW-1:0] amt;
  logic [W-1:0]  shl, shr, sha;

  assign sub   = fn_i[4];
  assign b_eff = sub ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign amt   = a_i[SW-1:0];
  assign shl   = b_i << amt;
  assign shr   = b_i >> amt;
  assign sha   = $signed(b_i) >>> amt;

  always_comb begin
    r_o     = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    case (fn_i[1:0])
      2'b01: begin
        r_o     = sum[W-1:0];
        carry_o = sum[W];
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
      end
      2'b10: begin
        case (fn_i[3:2])
          2'b00:   r_o = shl;
          2'b10:   r_o = shr;
          2'b11:   r_o = sha;
          default: r_o = '0;
        endcase
      end
      2'b00: begin
        case (fn_i[3:2])
          2'b00:   r_o = a_i & b_i;
          2'b01:   r_o = a_i | b_i;
          2'b10:   r_o = a_i ^ b_i;
          default: r_o = ~(a_i | b_i);
        endcase
      end
      default: r_o = '0;
    endcase
  end

  assign neg_o  = r_o[W-1];
  assign zero_o = ~|r_o;
endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns / 1ps
module alu_flags_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   fn_i,
  input logic [W-1:0] r_o,
  input logic         neg_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         zero_o
);
  localparam logic signed [W:0] SMAX = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] SMIN = {2'b11, {(W-1){1'b0}}};

  logic [W:0]        add_ref;
  logic [W-1:0]      sub_ref;
  logic signed [W:0] sadd;
  logic              add_fits;
  logic              is_add, is_sub, is_plain, is_none;

  assign add_ref  = {1'b0, a_i} + {1'b0, b_i};
  assign sub_ref  = a_i - b_i;
  assign sadd     = $signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i});
  assign add_fits = (sadd <= SMAX) && (sadd >= SMIN);

  always_comb begin
    is_add = 1'b0; is_sub = 1'b0; is_plain = 1'b0; is_none = 1'b0;
    casez (fn_i)
      5'b0??01: is_add = 1'b1;
      5'b1??01: is_sub = 1'b1;
      5'b?0010, 5'b?1010, 5'b?1110,
      5'b?0000, 5'b?0100, 5'b?1000, 5'b?1100: is_plain = 1'b1;
      default: is_none = 1'b1;
    endcase
  end

  always_comb begin
    // R1
    add_sum_chk: assert (!is_add || {carry_o, r_o} == add_ref);
    // R2
    sub_diff_chk: assert (!is_sub || (r_o == sub_ref && carry_o == (a_i >= b_i)));
    // R3
    add_ovf_chk: assert (!is_add || ovf_o == !add_fits);
    // R9
    quiet_flag_chk: assert (!is_plain || (!carry_o && !ovf_o));
    // R11
    unlisted_zero_chk: assert (!is_none || (r_o == '0 && zero_o && !carry_o && !ovf_o));
    // R12
    zero_neg_chk: assert (zero_o == (r_o == '0) && neg_o == r_o[W-1]);
  end
endmodule

bind alu_flags alu_flags_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu_flags.sv
`timescale 1ns / 1ps
module sim_alu_flags;
  localparam int W = 8;
  localparam logic [4:0] ADD = 5'b00001, SUB = 5'b10001, SLL = 5'b00010,
                         SRL = 5'b01010, SRA = 5'b01110, AND_ = 5'b00000,
                         OR_ = 5'b00100, XOR_ = 5'b01000, NOR_ = 5'b01100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, r;
  logic [4:0]   fn;
  logic         n, c, v, z;
  int checks = 0, fails = 0;

  alu_flags #(.W(W)) u0 (.a_i(a), .b_i(b), .fn_i(fn), .r_o(r),
                         .neg_o(n), .carry_o(c), .ovf_o(v), .zero_o(z));

  function automatic logic [W+3:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [4:0] f);
    int m = 1 << W;
    int sx = (int'(x) >= m/2) ? int'(x) - m : int'(x);
    int sy = (int'(y) >= m/2) ? int'(y) - m : int'(y);
    int sh = int'(x) % W;
    int t, s;
    logic [W-1:0] rr = '0;
    logic cc = 1'b0, vv = 1'b0;
    casez (f)
      5'b0??01: begin t = int'(x) + int'(y); rr = W'(t % m); cc = (t >= m);
                      s = sx + sy; vv = (s >= m/2) || (s < -m/2); end
      5'b1??01: begin t = int'(x) - int'(y) + m; rr = W'(t % m); cc = (x >= y);
                      s = sx - sy; vv = (s >= m/2) || (s < -m/2); end
      5'b?0010: rr = W'((int'(y) << sh) % m);
      5'b?1010: rr = W'(int'(y) >> sh);
      5'b?1110: rr = W'(int'(y) >> sh) | (y[W-1] ? ~({W{1'b1}} >> sh) : '0);
      5'b?0000: rr = x & y;
      5'b?0100: rr = x | y;
      5'b?1000: rr = x ^ y;
      5'b?1100: rr = ~(x | y);
      default:  rr = '0;
    endcase
    return {rr[W-1], cc, vv, (rr == '0), rr};
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [4:0] f);
    @(posedge clk);
    a = x; b = y; fn = f;
    @(negedge clk);
  endtask

  task automatic expect_all(string tag, logic [W-1:0] er, logic en, logic ec, logic ev, logic ez);
    chk(tag, "r", r, er);
    chk(tag, "n", W'(n), W'(en));
    chk(tag, "c", W'(c), W'(ec));
    chk(tag, "v", W'(v), W'(ev));
    chk(tag, "z", W'(z), W'(ez));
  endtask

  task automatic vs_model(string tag);
    logic [W+3:0] e = model(a, b, fn);
    expect_all(tag, e[W-1:0], e[W+3], e[W+2], e[W+1], e[W]);
  endtask

  task automatic t_reset;
    apply('0, '0, AND_);
    expect_all("R12 idle", 8'h00, 0, 0, 0, 1);
  endtask

  task automatic t_add;
    apply(8'd10, 8'd20, ADD);   expect_all("R1 10+20", 8'd30, 0, 0, 0, 0);
    apply(8'd100, 8'd30, ADD);  expect_all("R3 100+30", 8'd130, 1, 0, 1, 0);
    apply(8'hFF, 8'h01, ADD);   expect_all("R1 wrap", 8'h00, 0, 1, 0, 1);
    apply(8'h80, 8'h80, ADD);   expect_all("R3 neg+neg", 8'h00, 0, 1, 1, 1);
  endtask

  task automatic t_sub;
    apply(8'd10, 8'd20, SUB);   expect_all("R2 10-20", 8'hF6, 1, 0, 0, 0);
    apply(8'd1, 8'd1, SUB);     expect_all("R2 1-1", 8'h00, 0, 1, 0, 1);
    apply(8'h80, 8'h01, SUB);   expect_all("R3 min-1", 8'h7F, 0, 1, 1, 0);
    apply(8'd5, 8'd3, 5'b11101); expect_all("R2 dontcare", 8'd2, 0, 1, 0, 0);
  endtask

  task automatic t_shift;
    apply(8'd2, 8'd20, SLL);    expect_all("R4 sll", 8'd80, 0, 0, 0, 0);
    apply(8'd2, 8'd20, SRL);    expect_all("R5 srl", 8'd5, 0, 0, 0, 0);
    apply(8'd1, 8'hFE, SRA);    expect_all("R6 sra", 8'hFF, 1, 0, 0, 0);
    apply(8'd3, 8'h90, SRL);    expect_all("R5 srl neg", 8'h12, 0, 0, 0, 0);
    apply(8'd3, 8'h90, SRA);    expect_all("R6 sra neg", 8'hF2, 1, 0, 0, 0);
    apply(8'd7, 8'h81, SLL);    expect_all("R9 sll top", 8'h80, 1, 0, 0, 0);
  endtask

  task automatic t_logic;
    apply(8'hF0, 8'h3C, AND_);  expect_all("R7 and", 8'h30, 0, 0, 0, 0);
    apply(8'hF0, 8'h3C, OR_);   expect_all("R7 or", 8'hFC, 1, 0, 0, 0);
    apply(8'hF0, 8'h3C, XOR_);  expect_all("R7 xor", 8'hCC, 1, 0, 0, 0);
    apply(8'hF0, 8'h3C, NOR_);  expect_all("R7 nor", 8'h03, 0, 0, 0, 0);
  endtask

  task automatic t_bit4;
    apply(8'hF0, 8'h3C, 5'b10000); expect_all("R8 and", 8'h30, 0, 0, 0, 0);
    apply(8'hF0, 8'h3C, 5'b11100); expect_all("R8 nor", 8'h03, 0, 0, 0, 0);
    apply(8'd2, 8'd20, 5'b10010);  expect_all("R8 sll", 8'd80, 0, 0, 0, 0);
    apply(8'd1, 8'hFE, 5'b11110);  expect_all("R8 sra", 8'hFF, 1, 0, 0, 0);
  endtask

  task automatic t_amount;
    apply(8'h0A, 8'd20, SLL);   expect_all("R10 sll", 8'd80, 0, 0, 0, 0);
    apply(8'h08, 8'd20, SRL);   expect_all("R10 srl", 8'd20, 0, 0, 0, 0);
    apply(8'hF9, 8'h80, SRA);   expect_all("R10 sra", 8'hC0, 1, 0, 0, 0);
  endtask

  task automatic t_unlisted;
    apply(8'hFF, 8'h01, 5'b00011); expect_all("R11 x11", 8'h00, 0, 0, 0, 1);
    apply(8'hFF, 8'hFF, 5'b11111); expect_all("R11 all1", 8'h00, 0, 0, 0, 1);
    apply(8'd1, 8'hFE, 5'b00110);  expect_all("R11 x0110", 8'h00, 0, 0, 0, 1);
  endtask

  task automatic t_sweep;
    logic [4:0] fns [9] = '{ADD, SUB, SLL, SRL, SRA, AND_, OR_, XOR_, NOR_};
    for (int i = 0; i < 9; i++)
      for (int x = 0; x < 256; x += 37)
        for (int y = 0; y < 256; y += 29) begin
          apply(W'(x), W'(y), fns[i]);
          vs_model("R12 sweep");
        end
  endtask

  initial begin
    a = '0; b = '0; fn = '0;
    t_reset;
    t_add;
    t_sub;
    t_shift;
    t_logic;
    t_bit4;
    t_amount;
    t_unlisted;
    t_sweep;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule